// File: doc/BRIEF.md
# Programmable Almost-Full / Almost-Empty Flag Unit

This block produces the almost-empty and almost-full status flags for a pair of FIFOs, each 4096 entries deep. Each FIFO supplies its current occupancy count. The unit compares that count against two 12-bit thresholds per FIFO. The empty-side threshold (the "low mark") is compared with occupancy. The full-side threshold (the "high mark") is compared with free space. Both flags are active low and come from registers, so each flag reflects the occupancy and thresholds that were present at the previous clock edge.

While master reset is held low, a 3-bit configuration select chooses how the four thresholds are set. The value of the select in the last reset cycle is the one that is kept. The three methods are:
- a fixed preset written into all four registers,
- a parallel load over a valid/ready stream,
- a serial load that shifts one bit per clock through a 48-bit chain.

A partial reset forces the flags to their reset levels. It keeps the thresholds, the chosen method and any load progress. The memory array and the crossing of the flags into other clock domains belong to the surrounding FIFO.

Top module: `aflag_unit`

## Requirements
- R1: In each cycle with `mrst_n` low, `cfg_sel` is decoded and the decode from the final reset cycle stays in force. The codes are: 0 selects serial loading; 1 or 7 selects parallel loading; 2, 3, 4, 5 and 6 write the preset 8, 16, 64, 256 and 1024 into all four threshold registers.
- R2: Under codes 0, 1 and 7, master reset clears all four thresholds to zero. As a result, almost-empty asserts only at occupancy 0 and almost-full asserts only at occupancy 4096.
- R3: The clock edge after any cycle with `mrst_n` or `prst_n` low leaves every almost-empty output low (asserted) and every almost-full output high (deasserted).
- R4: Outside reset, almost-empty of FIFO A (B) is low exactly when the occupancy sampled at the previous edge is at or below low mark A (B).
- R5: Outside reset, almost-full of FIFO A (B) is low exactly when 4096 minus the sampled occupancy is at or below high mark A (B).
- R6: In serial mode, each edge with `ser_en_n` low shifts `ser_din` into the chain. The chain, from its first end to its last, is low mark A, high mark A, low mark B, high mark B, each 12 bits and loaded MSB first. After 48 shifts the first bit sits in the MSB of low mark A and the last bit sits in the LSB of high mark B.
- R7: In serial mode, edges with `ser_en_n` high do not shift. Once 48 bits have been taken, further serial bits are ignored until the next master reset.
- R8: In parallel mode, `par_ready` is high until four transfers have completed. Transfers (`par_valid` and `par_ready` both high at an edge) write low mark A, high mark A, low mark B and high mark B, in that order. After the fourth transfer `par_ready` stays low and `par_valid` is ignored. Outside parallel mode, `par_ready` is always low.
- R9: A partial reset leaves the thresholds, the load method and the serial/parallel load progress unchanged.
- R10: While `mrst_n` or `prst_n` is low, `par_ready` is low and no serial or parallel write takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| mrst_n | input | 1 | Master reset, active low, synchronous |
| prst_n | input | 1 | Partial reset, active low, synchronous |
| cfg_sel | input | 3 | Method/preset select, decoded during master reset |
| ser_din | input | 1 | Serial threshold data bit |
| ser_en_n | input | 1 | Serial shift enable, active low |
| par_valid | input | 1 | Parallel threshold word valid |
| par_ready | output | 1 | Unit accepts a parallel threshold word |
| par_data | input | 12 | Parallel threshold word |
| occ_a | input | 13 | Occupancy of FIFO A (0..4096) |
| occ_b | input | 13 | Occupancy of FIFO B (0..4096) |
| alm_empty_a_n | output | 1 | Almost-empty of FIFO A, active low |
| alm_full_a_n | output | 1 | Almost-full of FIFO A, active low |
| alm_empty_b_n | output | 1 | Almost-empty of FIFO B, active low |
| alm_full_b_n | output | 1 | Almost-full of FIFO B, active low |

## Verification
A wrong threshold value stays hidden until an occupancy near that threshold is applied. The flag then flips at the wrong count on the very next edge. For this reason the bench steps occupancy through a window of counts around every threshold after each configuration.

A serial chain that is misordered or shifted by one bit moves bits between neighbouring registers. This shows up as a threshold off by a power of two, or as the wrong FIFO's threshold. A wrong parallel index or load counter shows up in `par_ready` within one cycle, and in the flags once the register it wrongly wrote is probed.

// File: rtl/aflag_pkg.sv
package aflag_pkg;

  typedef enum logic [1:0] {
    LD_SERIAL   = 2'd0,
    LD_PARALLEL = 2'd1,
    LD_PRESET   = 2'd2
  } load_mode_e;

  function automatic load_mode_e decode_mode(input logic [2:0] sel);
    case (sel)
      3'd0:       decode_mode = LD_SERIAL;
      3'd1, 3'd7: decode_mode = LD_PARALLEL;
      default:    decode_mode = LD_PRESET;
    endcase
  endfunction

  function automatic int unsigned preset_value(input logic [2:0] sel);
    case (sel)
      3'd2:    preset_value = 8;
      3'd3:    preset_value = 16;
      3'd4:    preset_value = 64;
      3'd5:    preset_value = 256;
      3'd6:    preset_value = 1024;
      default: preset_value = 0;
    endcase
  endfunction

endpackage

// File: rtl/aflag_cfg.sv
module aflag_cfg
  import aflag_pkg::*;
#(
  parameter int OFS_W  = 12,
  parameter int NUM_CH = 2,
  localparam int NREG    = 2 * NUM_CH,
  localparam int CHAIN_W = NREG * OFS_W,
  localparam int SCNT_W  = $clog2(CHAIN_W + 1),
  localparam int PIDX_W  = $clog2(NREG + 1)
) (
  input  logic                           clk,
  input  logic                           mrst_n,
  input  logic                           prst_n,
  input  logic [2:0]                     cfg_sel,
  input  logic                           ser_din,
  input  logic                           ser_en_n,
  input  logic                           par_valid,
  output logic                           par_ready,
  input  logic [OFS_W-1:0]               par_data,
  output logic [NUM_CH-1:0][OFS_W-1:0]   ofs_lo,
  output logic [NUM_CH-1:0][OFS_W-1:0]   ofs_hi
);

  // regs[NREG-1] is the head of the serial chain (low mark of channel 0)
  logic [NREG-1:0][OFS_W-1:0] regs;
  load_mode_e                 mode;
  logic [SCNT_W-1:0]          ser_cnt;
  logic [PIDX_W-1:0]          par_idx;
  logic                       run;
  logic                       ser_fire;
  logic                       par_fire;
  logic [CHAIN_W-1:0]         chain;

  assign run      = mrst_n && prst_n;
  assign chain    = regs;
  assign ser_fire = run && (mode == LD_SERIAL) && !ser_en_n
                    && (ser_cnt < SCNT_W'(CHAIN_W));
  assign par_ready = run && (mode == LD_PARALLEL) && (par_idx < PIDX_W'(NREG));
  assign par_fire  = par_ready && par_valid;

  always_ff @(posedge clk) begin
    if (!mrst_n) begin
      mode    <= decode_mode(cfg_sel);
      ser_cnt <= '0;
      par_idx <= '0;
      for (int i = 0; i < NREG; i++) begin
        regs[i] <= OFS_W'(preset_value(cfg_sel));
      end
    end else begin
      if (ser_fire) begin
        regs    <= {chain[CHAIN_W-2:0], ser_din};
        ser_cnt <= ser_cnt + 1'b1;
      end
      if (par_fire) begin
        regs[NREG-1-int'(par_idx)] <= par_data;
        par_idx <= par_idx + 1'b1;
      end
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_map
    assign ofs_lo[c] = regs[NREG-1-2*c];
    assign ofs_hi[c] = regs[NREG-2-2*c];
  end

  // R1 / R9: the method only moves while master reset is low
  p_mode_hold_r9 : assert property (@(posedge clk) disable iff (!mrst_n)
    1'b1 |=> $stable(mode));

  // R9 / R10: partial reset freezes thresholds
  p_prst_hold_r9 : assert property (@(posedge clk) disable iff (!mrst_n)
    !prst_n |=> $stable(regs));

  // R7: idle serial enable with no parallel transfer leaves thresholds
  p_ser_idle_r7 : assert property (@(posedge clk) disable iff (!mrst_n)
    (ser_en_n && !(par_valid && par_ready)) |=> $stable(regs));

  // R7: chain closed after the full bit count
  p_ser_limit_r7 : assert property (@(posedge clk) disable iff (!mrst_n)
    (ser_cnt == SCNT_W'(CHAIN_W)) |=> $stable(regs));

  // R8: each accepted word advances the register index by one
  p_par_step_r8 : assert property (@(posedge clk) disable iff (!mrst_n)
    (par_valid && par_ready) |=> (par_idx == $past(par_idx) + 1'b1));

endmodule

// File: rtl/aflag_cmp.sv
module aflag_cmp #(
  parameter int DEPTH = 4096,
  parameter int OFS_W = 12,
  localparam int CNT_W = OFS_W + 1
) (
  input  logic             clk,
  input  logic             rst_any,
  input  logic [CNT_W-1:0] occ,
  input  logic [OFS_W-1:0] ofs_lo,
  input  logic [OFS_W-1:0] ofs_hi,
  output logic             alm_empty_n,
  output logic             alm_full_n
);

  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

  logic [CNT_W-1:0] free_cnt;
  logic             near_empty;
  logic             near_full;

  assign free_cnt   = DEPTH_C - occ;
  assign near_empty = occ <= {1'b0, ofs_lo};
  assign near_full  = free_cnt <= {1'b0, ofs_hi};

  always_ff @(posedge clk) begin
    if (rst_any) begin
      alm_empty_n <= 1'b0;
      alm_full_n  <= 1'b1;
    end else begin
      alm_empty_n <= !near_empty;
      alm_full_n  <= !near_full;
    end
  end

  // R3: reset levels of both flags one edge after any reset cycle
  p_reset_flags_r3 : assert property (@(posedge clk)
    rst_any |=> (!alm_empty_n && alm_full_n));

  // R4: an empty FIFO always reports almost-empty
  p_zero_empty_r4 : assert property (@(posedge clk) disable iff (rst_any)
    (occ == '0) |=> !alm_empty_n);

endmodule

// File: rtl/aflag_unit.sv
module aflag_unit #(
  parameter int DEPTH = 4096,
  localparam int OFS_W = $clog2(DEPTH),
  localparam int CNT_W = OFS_W + 1
) (
  input  logic             clk,
  input  logic             mrst_n,
  input  logic             prst_n,
  input  logic [2:0]       cfg_sel,
  input  logic             ser_din,
  input  logic             ser_en_n,
  input  logic             par_valid,
  output logic             par_ready,
  input  logic [OFS_W-1:0] par_data,
  input  logic [CNT_W-1:0] occ_a,
  input  logic [CNT_W-1:0] occ_b,
  output logic             alm_empty_a_n,
  output logic             alm_full_a_n,
  output logic             alm_empty_b_n,
  output logic             alm_full_b_n
);

  localparam int NUM_CH = 2;

  logic [NUM_CH-1:0][OFS_W-1:0] ofs_lo;
  logic [NUM_CH-1:0][OFS_W-1:0] ofs_hi;
  logic [NUM_CH-1:0][CNT_W-1:0] occ_v;
  logic [NUM_CH-1:0]            ae_n_v;
  logic [NUM_CH-1:0]            af_n_v;
  logic                         rst_any;

  assign rst_any = !mrst_n || !prst_n;
  assign occ_v   = {occ_b, occ_a};

  aflag_cfg #(.OFS_W(OFS_W), .NUM_CH(NUM_CH)) u_cfg (
    .clk       (clk),
    .mrst_n    (mrst_n),
    .prst_n    (prst_n),
    .cfg_sel   (cfg_sel),
    .ser_din   (ser_din),
    .ser_en_n  (ser_en_n),
    .par_valid (par_valid),
    .par_ready (par_ready),
    .par_data  (par_data),
    .ofs_lo    (ofs_lo),
    .ofs_hi    (ofs_hi)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    aflag_cmp #(.DEPTH(DEPTH), .OFS_W(OFS_W)) u_cmp (
      .clk         (clk),
      .rst_any     (rst_any),
      .occ         (occ_v[c]),
      .ofs_lo      (ofs_lo[c]),
      .ofs_hi      (ofs_hi[c]),
      .alm_empty_n (ae_n_v[c]),
      .alm_full_n  (af_n_v[c])
    );
  end

  assign alm_empty_a_n = ae_n_v[0];
  assign alm_full_a_n  = af_n_v[0];
  assign alm_empty_b_n = ae_n_v[1];
  assign alm_full_b_n  = af_n_v[1];

  // R10: no parallel acceptance during any reset
  p_ready_rst_r10 : assert property (@(posedge clk)
    rst_any |-> !par_ready);

endmodule

// File: tb/aflag_unit_tb_top.sv
module aflag_unit_tb_top;

  localparam int DEPTH = 4096;
  localparam int MASK  = 4095;

  logic        clk = 1'b0;
  logic        mrst_n = 1'b0;
  logic        prst_n = 1'b1;
  logic [2:0]  cfg_sel = 3'd4;
  logic        ser_din = 1'b0;
  logic        ser_en_n = 1'b1;
  logic        par_valid = 1'b0;
  logic        par_ready;
  logic [11:0] par_data = '0;
  logic [12:0] occ_a = '0;
  logic [12:0] occ_b = '0;
  logic        alm_empty_a_n, alm_full_a_n, alm_empty_b_n, alm_full_b_n;

  always #2.5 clk = ~clk;

  aflag_unit dut_i (
    .clk(clk), .mrst_n(mrst_n), .prst_n(prst_n), .cfg_sel(cfg_sel),
    .ser_din(ser_din), .ser_en_n(ser_en_n), .par_valid(par_valid),
    .par_ready(par_ready), .par_data(par_data), .occ_a(occ_a), .occ_b(occ_b),
    .alm_empty_a_n(alm_empty_a_n), .alm_full_a_n(alm_full_a_n),
    .alm_empty_b_n(alm_empty_b_n), .alm_full_b_n(alm_full_b_n)
  );

  // reference model: v[0]=low A, v[1]=high A, v[2]=low B, v[3]=high B
  int    v[4];
  int    m_mode;   // 0 serial, 1 parallel, 2 preset
  int    m_scnt, m_pidx;
  bit    e_ae[2], e_af[2];
  bit    e_rst;
  bit    started = 0, done = 0;
  int    checks = 0, failures = 0;
  string phase = "R1";

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    int occ[2];
    int s;
    bit rst;
    occ[0] = int'(occ_a);
    occ[1] = int'(occ_b);
    rst = !mrst_n || !prst_n;
    e_rst = rst;
    for (int c = 0; c < 2; c++) begin
      e_ae[c] = rst ? 1'b0 : !(occ[c] <= v[2*c]);
      e_af[c] = rst ? 1'b1 : !((DEPTH - occ[c]) <= v[2*c+1]);
    end
    if (!mrst_n) begin
      s = int'(cfg_sel);
      m_mode = (s == 0) ? 0 : ((s == 1 || s == 7) ? 1 : 2);
      for (int k = 0; k < 4; k++)
        v[k] = (s == 2) ? 8 : (s == 3) ? 16 : (s == 4) ? 64 :
               (s == 5) ? 256 : (s == 6) ? 1024 : 0;
      m_scnt = 0;
      m_pidx = 0;
    end else if (prst_n) begin
      if (m_mode == 0 && !ser_en_n && m_scnt < 48) begin
        int nv[4];
        for (int k = 0; k < 4; k++) begin
          int inb;
          inb = (k == 3) ? int'(ser_din) : ((v[k+1] >> 11) & 1);
          nv[k] = ((v[k] << 1) | inb) & MASK;
        end
        for (int k = 0; k < 4; k++) v[k] = nv[k];
        m_scnt++;
      end
      if (m_mode == 1 && par_valid && m_pidx < 4) begin
        v[m_pidx] = int'(par_data);
        m_pidx++;
      end
    end
    started = 1;
  end

  always @(negedge clk) begin
    if (started && !done) begin
      string t;
      t = e_rst ? "R3" : phase;
      chk({t, " empty_a"}, alm_empty_a_n, e_ae[0]);
      chk({t, " full_a"},  alm_full_a_n,  e_af[0]);
      chk({t, " empty_b"}, alm_empty_b_n, e_ae[1]);
      chk({t, " full_b"},  alm_full_b_n,  e_af[1]);
      chk((mrst_n && prst_n) ? "R8 ready" : "R10 ready", par_ready,
          (m_mode == 1 && m_pidx < 4 && mrst_n && prst_n));
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic mreset(input logic [2:0] s);
    mrst_n = 1'b0;
    cfg_sel = s;
    repeat (3) step();
    cfg_sel = 3'd0;
    mrst_n = 1'b1;
    step();
  endtask

  task automatic preset_pulse(input int n);
    prst_n = 1'b0;
    repeat (n) step();
    prst_n = 1'b1;
  endtask

  function automatic logic [12:0] clampc(input int x);
    if (x < 0) return 13'd0;
    if (x > DEPTH) return 13'(DEPTH);
    return 13'(x);
  endfunction

  // R4 / R5: sweep occupancy around every threshold
  task automatic probe();
    for (int d = -2; d <= 2; d++) begin
      occ_a = clampc(v[0] + d);
      occ_b = clampc(DEPTH - v[3] + d);
      step();
      occ_a = clampc(DEPTH - v[1] + d);
      occ_b = clampc(v[2] + d);
      step();
    end
    occ_a = 13'd0; occ_b = 13'(DEPTH); step();
    occ_a = 13'(DEPTH); occ_b = 13'd0; step();
    occ_a = 13'd2048; occ_b = 13'd1; step();
  endtask

  task automatic ser_word(input int val);
    for (int b = 11; b >= 0; b--) begin
      ser_din = 1'((val >> b) & 1);
      ser_en_n = 1'b0;
      step();
      ser_en_n = 1'b1;
      if (b == 6) step();   // idle gap, R7
    end
  endtask

  task automatic par_word(input int val);
    par_data = 12'(val);
    par_valid = 1'b1;
    step();
    par_valid = 1'b0;
    step();
  endtask

  initial begin
    phase = "R1";
    mreset(3'd4); probe();
    phase = "R9";
    preset_pulse(2); probe();
    phase = "R1";
    mreset(3'd6); probe();
    mreset(3'd2); probe();
    mreset(3'd5); probe();
    mreset(3'd3); probe();
    phase = "R2";
    mreset(3'd0); probe();
    mreset(3'd7); probe();
    // serial load with a partial reset in the middle
    phase = "R6";
    mreset(3'd0);
    ser_word(100);
    preset_pulse(2);            // R9: progress retained
    ser_word(4000);
    ser_word(300);
    ser_word(1);
    phase = "R7";
    for (int i = 0; i < 5; i++) begin
      ser_din = 1'b1; ser_en_n = 1'b0; step();
    end
    ser_en_n = 1'b1;
    probe();
    // parallel load
    phase = "R8";
    mreset(3'd1);
    par_word(12);
    prst_n = 1'b0; par_valid = 1'b1; par_data = 12'd999; step(); // R10
    prst_n = 1'b1; par_valid = 1'b0; step();
    par_word(3500);
    par_word(2047);
    par_word(4095);
    par_word(77);               // ignored after four
    probe();
    phase = "R10";
    mrst_n = 1'b0; cfg_sel = 3'd1; ser_en_n = 1'b0; par_valid = 1'b1; step();
    mrst_n = 1'b1; ser_en_n = 1'b1; par_valid = 1'b0; step();
    probe();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule